// File: doc/BRIEF.md
# RS485 Half-Duplex Line Direction Controller

This block drives the enable line of an RS485 transceiver's line driver for half-duplex links. It watches the status of a UART transmitter: a busy flag that covers queued data and a flag that reports an empty shift register. While the transmitter has anything in flight, the direction output stays high. When the final stop bit has left the shifter, the block counts a programmable number of whole bit times on the transmitter's bit-tick enable. It then drops the output so that the transceiver can listen for the far end's reply.

The mode is turned on in one of two ways. The first is an active-low strap input, sampled on the first clock after reset. The second is a software enable bit. While the mode is off, the direction output carries a plain software-driven level and the countdown is held cleared. While the mode is on, the transmit-empty indication is taken from the shifter-empty flag instead of the holding-register-empty flag. This keeps an interrupt from firing before the last character has physically left the wire.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset with the strap inactive (high) and the software enable low, dir_o equals sw_dir_i and tx_empty_o equals thr_empty_i.
- R2: The mode is enabled when sw_en_i is high, or when strap_n_i was low on the first clock edge after reset. Later changes of strap_n_i have no effect until the next reset.
- R3: While the mode is disabled, dir_o follows sw_dir_i, tx_empty_o follows thr_empty_i, and transmitter activity does not affect either output.
- R4: While the mode is enabled, dir_o is high in every cycle in which transmitter activity is present (tx_busy_i high or tsr_empty_i low).
- R5: When activity ends, the controller captures delay_i (4 bits, value D). dir_o stays high until the clock edge that samples the (D+1)th bit_tick_i pulse after that, and is low from then on.
- R6: With a delay setting of 0, dir_o drops on the first bit tick after activity ends.
- R7: Activity that returns during the countdown cancels it and keeps dir_o high. A full new countdown, using a freshly captured delay, starts when that activity ends.
- R8: While the mode is enabled, tx_empty_o equals tsr_empty_i regardless of thr_empty_i.
- R9: Changes to delay_i during a countdown do not alter that countdown's length.
- R10: Disabling the mode during a countdown returns the controller to idle. If the mode is then enabled again with no activity, dir_o is low and stays low across further bit ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_n_i | input | 1 | Active-low mode strap, sampled after reset |
| sw_en_i | input | 1 | Software mode enable |
| sw_dir_i | input | 1 | Software direction level used while the mode is off |
| tx_busy_i | input | 1 | Transmitter has data queued or in flight |
| tsr_empty_i | input | 1 | Transmit shift register empty |
| thr_empty_i | input | 1 | Transmit holding register empty |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| delay_i | input | DLY_W | Turnaround delay in bit times |
| dir_o | output | 1 | Line-driver enable / direction |
| tx_empty_o | output | 1 | Transmit-empty interrupt source |

## Verification
The bench builds the block with the default 4-bit delay field. That width makes the zero setting, small counts and a mid-countdown change of the setting cheap to walk through tick by tick. Bit ticks are driven by hand and sparsely, with idle cycles between them, so any countdown that advanced on plain clocks instead of ticks would show up. Two reset passes cover both enable paths, the strap and the software bit.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_XMIT = 2'd1,
    DIR_TURN = 2'd2
  } dir_state_e;
endpackage

// File: rtl/rs485_mode_sel.sv
module rs485_mode_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_n_i,
  input  logic sw_en_i,
  output logic en_o,
  output logic strap_en_o,
  output logic sampled_o
);
  logic strap_en_q, sampled_q;

  // strap captured once, on the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_en_q <= 1'b0;
      sampled_q  <= 1'b0;
    end else if (!sampled_q) begin
      strap_en_q <= ~strap_n_i;
      sampled_q  <= 1'b1;
    end
  end

  assign en_o       = strap_en_q | sw_en_i;
  assign strap_en_o = strap_en_q;
  assign sampled_o  = sampled_q;
endmodule

// File: rtl/rs485_turn_cnt.sv
module rs485_turn_cnt #(
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o,
  output logic [DLY_W-1:0] cnt_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       active_i,
  input  logic       tick_i,
  input  logic       cnt_zero_i,
  output dir_state_e state_o,
  output logic       load_o,
  output logic       dec_o,
  output logic       clr_o
);
  dir_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    dec_o   = 1'b0;
    if (!en_i) begin
      state_d = DIR_IDLE;
    end else begin
      unique case (state_q)
        DIR_IDLE: if (active_i) state_d = DIR_XMIT;
        DIR_XMIT: if (!active_i) begin
          state_d = DIR_TURN;
          load_o  = 1'b1;
        end
        DIR_TURN: begin
          if (active_i) state_d = DIR_XMIT;           // cancel countdown
          else if (tick_i) begin
            if (cnt_zero_i) state_d = DIR_IDLE;
            else            dec_o   = 1'b1;
          end
        end
        default: state_d = DIR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= DIR_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign clr_o   = ~en_i;
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_n_i,
  input  logic             sw_en_i,
  input  logic             sw_dir_i,
  input  logic             tx_busy_i,
  input  logic             tsr_empty_i,
  input  logic             thr_empty_i,
  input  logic             bit_tick_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             dir_o,
  output logic             tx_empty_o
);
  logic             mode_en, strap_en, strap_sampled;
  logic             active;
  logic             cnt_load, cnt_dec, cnt_clr, cnt_zero;
  logic [DLY_W-1:0] cnt_val;
  dir_state_e       state_q;

  assign active = tx_busy_i | ~tsr_empty_i;

  rs485_mode_sel i_mode_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strap_n_i  (strap_n_i),
    .sw_en_i    (sw_en_i),
    .en_o       (mode_en),
    .strap_en_o (strap_en),
    .sampled_o  (strap_sampled)
  );

  rs485_dir_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (mode_en),
    .active_i   (active),
    .tick_i     (bit_tick_i),
    .cnt_zero_i (cnt_zero),
    .state_o    (state_q),
    .load_o     (cnt_load),
    .dec_o      (cnt_dec),
    .clr_o      (cnt_clr)
  );

  rs485_turn_cnt #(.DLY_W(DLY_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cnt_clr),
    .load_i     (cnt_load),
    .load_val_i (delay_i),
    .dec_i      (cnt_dec),
    .zero_o     (cnt_zero),
    .cnt_o      (cnt_val)
  );

  assign dir_o      = mode_en ? (active | (state_q != DIR_IDLE)) : sw_dir_i;
  assign tx_empty_o = mode_en ? tsr_empty_i : thr_empty_i;
endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk
  import rs485_dir_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             strap_en_i,
  input logic             sampled_i,
  input logic             tx_busy_i,
  input logic             tsr_empty_i,
  input logic             bit_tick_i,
  input logic [DLY_W-1:0] delay_i,
  input logic [DLY_W-1:0] cnt_i,
  input dir_state_e       state_i,
  input logic             dir_o,
  input logic             tx_empty_o
);
  assert_strap_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sampled_i && $past(sampled_i) |-> $stable(strap_en_i));

  assert_off_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_i == DIR_IDLE && cnt_i == '0);

  assert_busy_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (tx_busy_i || !tsr_empty_i) |-> dir_o);

  assert_turn_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && state_i == DIR_TURN |-> dir_o);

  assert_release_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $past(en_i) && $fell(dir_o) |-> $past(state_i == DIR_TURN && bit_tick_i && cnt_i == '0));

  assert_cancel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && state_i == DIR_TURN && (tx_busy_i || !tsr_empty_i) |=> state_i == DIR_XMIT);

  assert_irq_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tsr_empty_i |-> !tx_empty_o);

  assert_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && state_i == DIR_XMIT && tx_busy_i == 1'b0 && tsr_empty_i |=> cnt_i == $past(delay_i));
endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk #(.DLY_W(DLY_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (mode_en),
  .strap_en_i  (strap_en),
  .sampled_i   (strap_sampled),
  .tx_busy_i   (tx_busy_i),
  .tsr_empty_i (tsr_empty_i),
  .bit_tick_i  (bit_tick_i),
  .delay_i     (delay_i),
  .cnt_i       (cnt_val),
  .state_i     (state_q),
  .dir_o       (dir_o),
  .tx_empty_o  (tx_empty_o)
);

// File: tb/test_rs485_dir_ctrl.sv
`timescale 1ns/1ps
module test_rs485_dir_ctrl;
  localparam int DLY_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic strap_n_i = 1'b1, sw_en_i = 1'b0, sw_dir_i = 1'b0;
  logic tx_busy_i = 1'b0, tsr_empty_i = 1'b1, thr_empty_i = 1'b1, bit_tick_i = 1'b0;
  logic [DLY_W-1:0] delay_i = '0;
  logic dir_o, tx_empty_o;

  // shadow stimulus, applied at the falling edge
  logic s_strap_n = 1'b1, s_sw_en = 1'b0, s_sw_dir = 1'b0;
  logic s_busy = 1'b0, s_tsr_e = 1'b1, s_thr_e = 1'b1, s_tick = 1'b0;
  logic [DLY_W-1:0] s_dly = '0;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [3:0] q_exp[$];   // {chk_dir, exp_dir, chk_irq, exp_irq}
  string      q_tag[$];

  always #2 clk = ~clk;

  rs485_dir_ctrl #(.DLY_W(DLY_W)) i_rs485_dir_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .strap_n_i(strap_n_i), .sw_en_i(sw_en_i),
    .sw_dir_i(sw_dir_i), .tx_busy_i(tx_busy_i), .tsr_empty_i(tsr_empty_i),
    .thr_empty_i(thr_empty_i), .bit_tick_i(bit_tick_i), .delay_i(delay_i),
    .dir_o(dir_o), .tx_empty_o(tx_empty_o)
  );

  task automatic apply();
    strap_n_i = s_strap_n; sw_en_i = s_sw_en; sw_dir_i = s_sw_dir;
    tx_busy_i = s_busy; tsr_empty_i = s_tsr_e; thr_empty_i = s_thr_e;
    bit_tick_i = s_tick; delay_i = s_dly;
  endtask

  // drive one cycle and queue what the outputs must show after the next rising edge
  task automatic step(input bit cd, input bit ed, input bit ci, input bit ei, input string tag);
    @(negedge clk);
    apply();
    q_exp.push_back({cd, ed, ci, ei});
    q_tag.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    apply();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() != 0) begin
        logic [3:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (e[3]) begin
          n_run++;
          if (dir_o !== e[2]) begin
            n_fail++;
            $display("FAIL %s dir_o actual=%0b expected=%0b", t, dir_o, e[2]);
          end
        end
        if (e[1]) begin
          n_run++;
          if (tx_empty_o !== e[0]) begin
            n_fail++;
            $display("FAIL %s tx_empty_o actual=%0b expected=%0b", t, tx_empty_o, e[0]);
          end
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(1, 0, 1, 1, "R1 reset state");
    // disabled mode
    s_busy = 1; step(1, 0, 0, 0, "R3 activity ignored");
    s_sw_dir = 1; step(1, 1, 0, 0, "R3 follows sw level");
    s_busy = 0; s_thr_e = 0; step(1, 1, 1, 0, "R3 irq from thr");
    s_thr_e = 1; s_tsr_e = 0; step(0, 0, 1, 1, "R3 irq ignores tsr");
    s_tsr_e = 1;
    // software enable
    s_sw_en = 1; step(1, 0, 1, 1, "R2 sw enable idle low");
    // R4
    s_busy = 1; step(1, 1, 0, 0, "R4 busy");
    step(1, 1, 0, 0, "R4 busy hold");
    s_busy = 0; s_tsr_e = 0; step(1, 1, 1, 0, "R4 shifter active");
    // R5 delay 2
    s_tsr_e = 1; s_dly = 2; step(1, 1, 0, 0, "R5 turnaround start");
    s_tick = 1; step(1, 1, 0, 0, "R5 tick1");
    s_tick = 0; step(1, 1, 0, 0, "R5 no tick");
    step(1, 1, 0, 0, "R5 no tick");
    s_tick = 1; step(1, 1, 0, 0, "R5 tick2");
    step(1, 0, 0, 0, "R5 tick3 release");
    s_tick = 0; step(1, 0, 0, 0, "R5 stays low");
    // R6 delay 0
    s_dly = 0; s_busy = 1; step(1, 1, 0, 0, "R6 busy");
    s_busy = 0; step(1, 1, 0, 0, "R6 hold");
    step(1, 1, 0, 0, "R6 hold without tick");
    s_tick = 1; step(1, 0, 0, 0, "R6 first tick release");
    s_tick = 0;
    // R9 delay captured
    s_dly = 3; s_busy = 1; step(1, 1, 0, 0, "R9 busy");
    s_busy = 0; step(1, 1, 0, 0, "R9 load");
    s_dly = 0; s_tick = 1;
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, "R9 still counting");
    step(1, 0, 0, 0, "R9 release after 4 ticks");
    s_tick = 0;
    // R7 cancel
    s_dly = 1; s_busy = 1; step(1, 1, 0, 0, "R7 busy");
    s_busy = 0; step(1, 1, 0, 0, "R7 load");
    s_tick = 1; step(1, 1, 0, 0, "R7 tick1");
    s_tick = 0; s_busy = 1; step(1, 1, 0, 0, "R7 cancel");
    s_busy = 0; step(1, 1, 0, 0, "R7 reload");
    s_tick = 1; step(1, 1, 0, 0, "R7 restarted tick1");
    step(1, 0, 0, 0, "R7 restarted tick2 release");
    s_tick = 0;
    // R8
    s_tsr_e = 0; s_thr_e = 1; step(1, 1, 1, 0, "R8 irq tsr busy");
    s_tsr_e = 1; s_thr_e = 0; s_busy = 1; step(1, 1, 1, 1, "R8 irq ignores thr");
    s_busy = 0; s_thr_e = 1; s_dly = 5; step(1, 1, 0, 0, "R10 countdown");
    // R10
    s_sw_en = 0; s_sw_dir = 0; step(1, 0, 1, 1, "R10 disable mid countdown");
    s_sw_en = 1; step(1, 0, 0, 0, "R10 reenabled idle");
    s_tick = 1; step(1, 0, 0, 0, "R10 tick stays low");
    step(1, 0, 0, 0, "R10 tick stays low");
    s_tick = 0;
    // strap path
    s_sw_en = 0; s_sw_dir = 1; s_strap_n = 0;
    do_reset();
    step(1, 0, 1, 1, "R2 strap enables");
    s_strap_n = 1; step(1, 0, 1, 1, "R2 strap change ignored");
    s_busy = 1; step(1, 1, 0, 0, "R2 strap mode drives high");
    s_busy = 0; step(0, 0, 0, 0, "");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule